// File: doc/BRIEF.md
# Multi-Channel UART Device Configuration Bank

This block sits between a host bus and a group of UART channels. It owns the device-wide control registers and forwards every write aimed at a channel register to that channel. The host sees one flat 8-bit address space. The lower half is split into one 16-register window per channel. The upper half holds the device-wide registers. Every enhanced channel register is reached directly by its offset, so no unlock value has to be written first.

The device-wide registers cover four things:
- a per-channel software reset that pulses once and clears itself;
- per-channel sleep enables;
- a per-channel choice between the normal sampling clock and a double-rate sampling clock;
- read-only identification bytes.

A broadcast bit changes how channel-window writes are delivered. While it is set, one such write reaches every channel, which shortens start-up code. Reads are never broadcast: a read always returns the data of the channel it addresses.

Top module: `uart_cfg_bank`

## Requirements
- R1: When `host_addr[7]` is 0, the address selects channel `host_addr[6:4]` and register offset `host_addr[3:0]`. A host write to an existing channel (number below NUM_CH) raises that channel's bit of `ch_we` for exactly one cycle, in the cycle after the write edge. In the same cycle `ch_offset` and `ch_wdata` carry the offset and data of that write. A write to a channel number of NUM_CH or above raises no `ch_we` bit.
- R2: Bit 0 of address 0x83 is the broadcast flag, and it reads back at that address. While the flag is 1, a write to an existing channel's window raises every bit of `ch_we` in the cycle after the write edge.
- R3: A read of a channel window returns that channel's byte from `ch_rdata` (channel c occupies bits 8c+7:8c), whether or not broadcast is set. A read of a channel number of NUM_CH or above returns 0.
- R4: Writing a 1 to bit i at address 0x80 raises `ch_rst[i]` for exactly the one cycle after the write edge. Address 0x80 always reads 0.
- R5: Bit i at address 0x81 drives `ch_sleep[i]`, is updated by each write to that address, and reads back. Bits at or above NUM_CH read 0.
- R6: Bit i at address 0x82 drives `ch_fast_sample[i]` (1 selects the double-rate sampling clock), is updated by each write to that address, and reads back. Bits at or above NUM_CH read 0.
- R7: Address 0x8E reads the DEV_ID parameter and address 0x8F reads the DEV_REV parameter. Writes to either address change neither value.
- R8: While `rst_n` is low, the broadcast, sleep and sampling-mode registers clear to 0. `ch_we` and `ch_rst` are 0 in the cycle after the reset.
- R9: Addresses 0x84 to 0x8D and 0x90 to 0xFF read 0. Writes to them change no output.
- R10: A write in the device region (`host_addr[7]` = 1) never raises `ch_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_we | input | 1 | Host write strobe, one write per cycle it is high |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| ch_rdata | input | 8*NUM_CH | Read bytes from the channels, channel c in bits 8c+7:8c |
| ch_we | output | NUM_CH | Per-channel register write enable |
| ch_offset | output | 4 | Register offset of the forwarded write |
| ch_wdata | output | 8 | Data of the forwarded write |
| ch_rst | output | NUM_CH | Per-channel software reset pulse |
| ch_sleep | output | NUM_CH | Per-channel sleep enable |
| ch_fast_sample | output | NUM_CH | Per-channel double-rate sampling select |

## Verification
All write effects are registered once. The forwarded write enables, the reset pulses and the new register contents all appear in the cycle that follows the write edge. Read data is combinational from the address and the current register state.

The bench applies inputs on the falling edge and ends a write on the next falling edge. It checks the registered outputs right there, half a cycle after they change. It checks the reset pulse once more one falling edge later to confirm that it has already gone. Reads settle for a short delay after the address changes before `host_rdata` is sampled.

The bench builds the design with six channels. This leaves two channel numbers in the address space that have no channel behind them, so the sweeps also cover the ignored channel windows.

// File: rtl/ucfg_pkg.sv
package ucfg_pkg;

    localparam int          CH_FIELD_W  = 3;
    localparam int          OFF_W       = 4;
    localparam int          BYTE_W      = 8;

    localparam logic [7:0]  ADDR_SWRST  = 8'h80;
    localparam logic [7:0]  ADDR_SLEEP  = 8'h81;
    localparam logic [7:0]  ADDR_SAMPLE = 8'h82;
    localparam logic [7:0]  ADDR_BCAST  = 8'h83;
    localparam logic [7:0]  ADDR_DEVID  = 8'h8E;
    localparam logic [7:0]  ADDR_DEVREV = 8'h8F;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SWRST,
        SEL_SLEEP,
        SEL_SAMPLE,
        SEL_BCAST,
        SEL_DEVID,
        SEL_DEVREV
    } cfg_sel_e;

    typedef struct packed {
        logic                  is_chan;
        logic                  chan_ok;
        logic [CH_FIELD_W-1:0] chan;
        logic [OFF_W-1:0]      offset;
        cfg_sel_e              sel;
    } addr_dec_t;

endpackage

// File: rtl/ucfg_addr_decode.sv
module ucfg_addr_decode
    import ucfg_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [7:0] addr_i,
    output addr_dec_t  dec_o
);

    always_comb begin
        dec_o         = '0;
        dec_o.is_chan = ~addr_i[7];
        dec_o.chan    = addr_i[6:4];
        dec_o.offset  = addr_i[3:0];
        dec_o.chan_ok = ~addr_i[7] && (int'(addr_i[6:4]) < NUM_CH);
        dec_o.sel     = SEL_NONE;
        if (addr_i[7]) begin
            unique case (addr_i)
                ADDR_SWRST:  dec_o.sel = SEL_SWRST;
                ADDR_SLEEP:  dec_o.sel = SEL_SLEEP;
                ADDR_SAMPLE: dec_o.sel = SEL_SAMPLE;
                ADDR_BCAST:  dec_o.sel = SEL_BCAST;
                ADDR_DEVID:  dec_o.sel = SEL_DEVID;
                ADDR_DEVREV: dec_o.sel = SEL_DEVREV;
                default:     dec_o.sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ucfg_chan_fanout.sv
module ucfg_chan_fanout
    import ucfg_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we_i,
    input  addr_dec_t           dec_i,
    input  logic [BYTE_W-1:0]   host_wdata_i,
    input  logic                bcast_i,
    output logic [NUM_CH-1:0]   ch_we_o,
    output logic [OFF_W-1:0]    ch_offset_o,
    output logic [BYTE_W-1:0]   ch_wdata_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] we;
        logic [OFF_W-1:0]  off;
        logic [BYTE_W-1:0] data;
    } fan_t;

    fan_t              fan_d, fan_q;
    logic [NUM_CH-1:0] hit;
    logic              chan_wr;

    assign chan_wr = host_we_i && dec_i.chan_ok;

    // One target per channel: either the addressed one or all of them.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign hit[i] = chan_wr && (bcast_i || (dec_i.chan == CH_FIELD_W'(i)));
    end

    always_comb begin
        fan_d    = fan_q;
        fan_d.we = hit;
        if (chan_wr) begin
            fan_d.off  = dec_i.offset;
            fan_d.data = host_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fan_q <= '0;
        else        fan_q <= fan_d;
    end

    assign ch_we_o     = fan_q.we;
    assign ch_offset_o = fan_q.off;
    assign ch_wdata_o  = fan_q.data;

    assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bcast_i) |-> $onehot0(ch_we_o));

    assert_bcast_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bcast_i) && $past(host_we_i) && $past(dec_i.chan_ok)) |-> (ch_we_o == '1));

    assert_we_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_we_o) |-> ($past(host_we_i) && $past(dec_i.is_chan)));

endmodule

// File: rtl/ucfg_ctrl_regs.sv
module ucfg_ctrl_regs
    import ucfg_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we_i,
    input  addr_dec_t         dec_i,
    input  logic [BYTE_W-1:0] host_wdata_i,
    output logic [NUM_CH-1:0] rst_pulse_o,
    output logic [NUM_CH-1:0] sleep_o,
    output logic [NUM_CH-1:0] sample_o,
    output logic              bcast_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] rst;
        logic [NUM_CH-1:0] sleep;
        logic [NUM_CH-1:0] sample;
        logic              bcast;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.rst = '0;
        if (host_we_i) begin
            unique case (dec_i.sel)
                SEL_SWRST:  ctrl_d.rst    = host_wdata_i[NUM_CH-1:0];
                SEL_SLEEP:  ctrl_d.sleep  = host_wdata_i[NUM_CH-1:0];
                SEL_SAMPLE: ctrl_d.sample = host_wdata_i[NUM_CH-1:0];
                SEL_BCAST:  ctrl_d.bcast  = host_wdata_i[0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign rst_pulse_o = ctrl_q.rst;
    assign sleep_o     = ctrl_q.sleep;
    assign sample_o    = ctrl_q.sample;
    assign bcast_o     = ctrl_q.bcast;

    assert_rst_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|rst_pulse_o) |-> ($past(host_we_i) && ($past(dec_i.sel) == SEL_SWRST)));

    assert_sleep_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(host_we_i) && ($past(dec_i.sel) == SEL_SLEEP)) |-> $stable(sleep_o));

    assert_sample_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(host_we_i) && ($past(dec_i.sel) == SEL_SAMPLE)) |-> $stable(sample_o));

    assert_bcast_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(host_we_i) && ($past(dec_i.sel) == SEL_BCAST)) |-> $stable(bcast_o));

endmodule

// File: rtl/ucfg_read_mux.sv
module ucfg_read_mux
    import ucfg_pkg::*;
#(
    parameter int              NUM_CH  = 8,
    parameter logic [BYTE_W-1:0] DEV_ID  = 8'h3C,
    parameter logic [BYTE_W-1:0] DEV_REV = 8'h02
) (
    input  addr_dec_t                 dec_i,
    input  logic [NUM_CH*BYTE_W-1:0]  ch_rdata_i,
    input  logic [NUM_CH-1:0]         sleep_i,
    input  logic [NUM_CH-1:0]         sample_i,
    input  logic                      bcast_i,
    output logic [BYTE_W-1:0]         rdata_o
);

    logic [BYTE_W-1:0] chan_byte;

    always_comb begin
        chan_byte = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (dec_i.chan == CH_FIELD_W'(c)) chan_byte = ch_rdata_i[c*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (dec_i.is_chan) begin
            if (dec_i.chan_ok) rdata_o = chan_byte;
        end else begin
            unique case (dec_i.sel)
                SEL_SLEEP:  rdata_o = BYTE_W'(sleep_i);
                SEL_SAMPLE: rdata_o = BYTE_W'(sample_i);
                SEL_BCAST:  rdata_o = {{(BYTE_W-1){1'b0}}, bcast_i};
                SEL_DEVID:  rdata_o = DEV_ID;
                SEL_DEVREV: rdata_o = DEV_REV;
                default:    rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/uart_cfg_bank.sv
module uart_cfg_bank
    import ucfg_pkg::*;
#(
    parameter int          NUM_CH  = 8,
    parameter logic [7:0]  DEV_ID  = 8'h3C,
    parameter logic [7:0]  DEV_REV = 8'h02
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            host_addr,
    input  logic [7:0]            host_wdata,
    input  logic                  host_we,
    output logic [7:0]            host_rdata,
    input  logic [NUM_CH*8-1:0]   ch_rdata,
    output logic [NUM_CH-1:0]     ch_we,
    output logic [3:0]            ch_offset,
    output logic [7:0]            ch_wdata,
    output logic [NUM_CH-1:0]     ch_rst,
    output logic [NUM_CH-1:0]     ch_sleep,
    output logic [NUM_CH-1:0]     ch_fast_sample
);

    addr_dec_t dec;
    logic      bcast;

    ucfg_addr_decode #(.NUM_CH(NUM_CH)) u_decode (
        .addr_i (host_addr),
        .dec_o  (dec)
    );

    ucfg_ctrl_regs #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_we_i    (host_we),
        .dec_i        (dec),
        .host_wdata_i (host_wdata),
        .rst_pulse_o  (ch_rst),
        .sleep_o      (ch_sleep),
        .sample_o     (ch_fast_sample),
        .bcast_o      (bcast)
    );

    ucfg_chan_fanout #(.NUM_CH(NUM_CH)) u_fanout (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_we_i    (host_we),
        .dec_i        (dec),
        .host_wdata_i (host_wdata),
        .bcast_i      (bcast),
        .ch_we_o      (ch_we),
        .ch_offset_o  (ch_offset),
        .ch_wdata_o   (ch_wdata)
    );

    ucfg_read_mux #(.NUM_CH(NUM_CH), .DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_rmux (
        .dec_i      (dec),
        .ch_rdata_i (ch_rdata),
        .sleep_i    (ch_sleep),
        .sample_i   (ch_fast_sample),
        .bcast_i    (bcast),
        .rdata_o    (host_rdata)
    );

    assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(host_we) |-> ((ch_we == '0) && (ch_rst == '0)));

endmodule

// File: tb/test_uart_cfg_bank.sv
`timescale 1ns/1ps
module test_uart_cfg_bank;

    localparam int         NCH = 6;
    localparam logic [7:0] ID  = 8'h5D;
    localparam logic [7:0] REV = 8'h07;
    localparam logic [NCH-1:0] ALL = '1;

    logic             clk = 0;
    logic             rst_n = 0;
    logic [7:0]       host_addr = 0;
    logic [7:0]       host_wdata = 0;
    logic             host_we = 0;
    logic [7:0]       host_rdata;
    logic [NCH*8-1:0] ch_rdata;
    logic [NCH-1:0]   ch_we, ch_rst, ch_sleep, ch_fast_sample;
    logic [3:0]       ch_offset;
    logic [7:0]       ch_wdata;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    uart_cfg_bank #(.NUM_CH(NCH), .DEV_ID(ID), .DEV_REV(REV)) i_uart_cfg_bank (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_rdata(host_rdata), .ch_rdata(ch_rdata),
        .ch_we(ch_we), .ch_offset(ch_offset), .ch_wdata(ch_wdata), .ch_rst(ch_rst),
        .ch_sleep(ch_sleep), .ch_fast_sample(ch_fast_sample)
    );

    function automatic logic [7:0] chan_pat(int c);
        return 8'(c * 37 + 11);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_we = 0;
        #1 d = host_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        for (int c = 0; c < NCH; c++) ch_rdata[c*8 +: 8] = chan_pat(c);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8: reset state
        chk("R8 we", 32'(ch_we), 0);
        chk("R8 rst", 32'(ch_rst), 0);
        chk("R8 sleep", 32'(ch_sleep), 0);
        chk("R8 fast", 32'(ch_fast_sample), 0);
        rd(8'h83, r); chk("R8 bcast", 32'(r), 0);

        // R7: identification, read-only
        rd(8'h8E, r); chk("R7 id", 32'(r), 32'(ID));
        rd(8'h8F, r); chk("R7 rev", 32'(r), 32'(REV));
        wr(8'h8E, 8'hFF);
        chk("R10 id write", 32'(ch_we), 0);
        wr(8'h8F, 8'h00);
        rd(8'h8E, r); chk("R7 id after write", 32'(r), 32'(ID));
        rd(8'h8F, r); chk("R7 rev after write", 32'(r), 32'(REV));

        // R1: every channel window and offset, no broadcast
        for (int c = 0; c < 8; c++) begin
            for (int o = 0; o < 16; o++) begin
                logic [7:0] d;
                d = 8'(c * 16 + o) ^ 8'h5A;
                wr(8'(c * 16 + o), d);
                chk("R1 we", 32'(ch_we), (c < NCH) ? 32'(1 << c) : 0);
                if (c < NCH) begin
                    chk("R1 offset", 32'(ch_offset), 32'(o));
                    chk("R1 data", 32'(ch_wdata), 32'(d));
                end
                @(negedge clk);
                chk("R1 we one cycle", 32'(ch_we), 0);
            end
        end

        // R3: reads of each channel window
        for (int c = 0; c < 8; c++) begin
            rd(8'(c * 16 + 9), r);
            chk("R3 read", 32'(r), (c < NCH) ? 32'(chan_pat(c)) : 0);
        end

        // R5 / R6: sleep and sampling mode patterns
        for (int p = 0; p < 4; p++) begin
            logic [7:0] v;
            v = (p == 0) ? 8'h15 : (p == 1) ? 8'hEA : (p == 2) ? 8'hFF : 8'h00;
            wr(8'h81, v);
            chk("R5 sleep out", 32'(ch_sleep), 32'(v[NCH-1:0]));
            rd(8'h81, r); chk("R5 sleep read", 32'(r), 32'(v & 8'h3F));
            wr(8'h82, ~v);
            chk("R6 fast out", 32'(ch_fast_sample), 32'(~v & 8'h3F));
            chk("R5 sleep kept", 32'(ch_sleep), 32'(v[NCH-1:0]));
            rd(8'h82, r); chk("R6 fast read", 32'(r), 32'(~v & 8'h3F));
        end

        // R4: software reset pulses
        for (int i = 0; i < 8; i++) begin
            wr(8'h80, 8'(1 << i));
            chk("R4 pulse", 32'(ch_rst), (i < NCH) ? 32'(1 << i) : 0);
            chk("R10 rst write", 32'(ch_we), 0);
            rd(8'h80, r);
            chk("R4 pulse ends", 32'(ch_rst), 0);
            chk("R4 reads zero", 32'(r), 0);
        end
        wr(8'h80, 8'hFF);
        chk("R4 all pulse", 32'(ch_rst), 32'(ALL));

        // R9: unmapped device addresses
        wr(8'h81, 8'h2C);
        wr(8'h82, 8'h13);
        for (int a = 8'h84; a <= 8'hFF; a++) begin
            if (a == 8'h8E || a == 8'h8F) continue;
            rd(8'(a), r);
            chk("R9 read zero", 32'(r), 0);
            if (a == 8'h84 || a == 8'h8D || a == 8'h90 || a == 8'hFF) begin
                wr(8'(a), 8'hFF);
                chk("R9 no we", 32'(ch_we), 0);
                chk("R9 no rst", 32'(ch_rst), 0);
                chk("R9 sleep kept", 32'(ch_sleep), 32'h2C);
                chk("R9 fast kept", 32'(ch_fast_sample), 32'h13);
                rd(8'h83, r); chk("R9 bcast kept", 32'(r), 0);
            end
        end

        // R2: broadcast writes
        wr(8'h83, 8'h01);
        rd(8'h83, r); chk("R2 bcast read", 32'(r), 1);
        for (int c = 0; c < 8; c++) begin
            wr(8'(c * 16 + c), 8'(8'hC0 + c));
            chk("R2 bcast we", 32'(ch_we), (c < NCH) ? 32'(ALL) : 0);
            if (c < NCH) begin
                chk("R2 bcast offset", 32'(ch_offset), 32'(c));
                chk("R2 bcast data", 32'(ch_wdata), 32'(8'hC0 + c));
            end
        end
        // R3: reads stay per channel under broadcast
        for (int c = 0; c < 8; c++) begin
            rd(8'(c * 16 + 2), r);
            chk("R3 read with bcast", 32'(r), (c < NCH) ? 32'(chan_pat(c)) : 0);
        end
        wr(8'h83, 8'h00);
        wr(8'h23, 8'h44);
        chk("R2 bcast off", 32'(ch_we), 32'(1 << 2));

        // R8: reset mid-run
        wr(8'h83, 8'h01);
        wr(8'h81, 8'h3F);
        wr(8'h82, 8'h3F);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R8 sleep cleared", 32'(ch_sleep), 0);
        chk("R8 fast cleared", 32'(ch_fast_sample), 0);
        rd(8'h83, r); chk("R8 bcast cleared", 32'(r), 0);
        wr(8'h10, 8'h99);
        chk("R8 no bcast after reset", 32'(ch_we), 32'(1 << 1));

        finish_run();
    end

endmodule